// File: doc/BRIEF.md
# Two-Way Translation Lookaside Buffer

This block keeps recently used page translations close to the pipeline so that most accesses avoid a page-table walk. It has two independent banks. One bank serves instruction fetch and the other serves data access. Each bank is a direct-indexed array of sets, and each set holds two ways. A way stores a 20-bit virtual page tag, the physical page number, a changed flag, and a cache-policy flag that is derived from the page-table entry. Pages are 4 KiB.

A requester presents a virtual address and an access kind using a valid/ready handshake. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. Exactly one cycle later the block pulses `rsp_valid` with a result of miss, hit, or changed-bit update required, together with the translated address and the cache-policy flag. The response has no back-pressure: the requester must capture it in the cycle it appears. The fill port and the invalidate port take priority over lookups. While either of them is valid, `req_ready` is low and any pending request must be held.

A page walker sits outside this block. It installs entries through the fill port. A maintenance agent clears one set index in both banks at once through the invalidate port.

Top module: `tlb2w_top`

## Requirements
- R1: Reset invalidates every way of every set in both banks, clears every recency bit, and holds `rsp_valid` low. After reset, every lookup misses until a fill has been made.
- R2: An accepted request produces exactly one response, with `rsp_valid` high for one cycle, on the clock edge after acceptance.
- R3: A lookup compares the address tag `req_va[31:12]` against both ways of the set selected by `req_va[17:12]`.
  - On a hit, `rsp_paddr` is the stored page number with `req_va[11:0]` appended.
  - On a miss, `rsp_res` is 0, `rsp_paddr` is 0 and `rsp_wi` is 0.
- R4: Access kind encoding: 0 = read, 1 = write, 2 = fetch, 3 = probe.
  - Fetch uses the instruction bank. Read, write and probe use the data bank.
  - A fill is directed to a bank by the same rule, using `fill_kind`.
- R5: The fill word uses this layout: bits 31..12 hold the physical page number, bit 7 is the changed flag, bit 6 is write-through, and bit 5 is cache-inhibit. On a hit, `rsp_wi` equals bit 6 OR bit 5.
- R6: Result encoding: 0 = miss, 1 = hit, 2 = update required.
  - A write that hits an entry whose changed flag is clear returns 2 and sets the stored flag, so the next write to that page returns 1.
  - Read, fetch and probe hits always return 1.
- R7: A hit by a read, write or fetch sets the set's recency bit to the way that hit. A probe hit leaves the recency bit unchanged.
- R8: A fill writes way 1 when the recency bit is 0 and way 0 holds a valid tag. Otherwise it writes way 0. The recency bit then names the way that was written.
- R9: A fill whose kind is probe (3) changes no entry.
- R10: An invalidate clears both ways at index `inv_index` in both banks and leaves other sets intact. If a fill and an invalidate address the same set in the same cycle, the set ends empty.
- R11: `req_ready` is low whenever `fill_valid` or `inv_valid` is high. A request that is not accepted produces no response.
- R12: The all-ones tag marks an invalid way. A lookup whose tag is all ones always misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup may be accepted this cycle |
| req_kind | input | 2 | Access kind (read, write, fetch, probe) |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_res | output | 2 | Result: miss, hit, update required |
| rsp_paddr | output | 32 | Translated physical address, zero on miss |
| rsp_wi | output | 1 | Write-through or cache-inhibited page |
| fill_valid | input | 1 | Install an entry this cycle |
| fill_kind | input | 2 | Access kind that selects the bank; probe is ignored |
| fill_va | input | 32 | Virtual address of the page being installed |
| fill_pte | input | 32 | Page-table entry second word |
| inv_valid | input | 1 | Invalidate a set this cycle |
| inv_index | input | 6 | Set index cleared in both banks |

## Verification
There are two cases where two functions meet in the same cycle.

The first is a lookup that coincides with a fill. To provoke it, the bench drives `req_valid` in the same cycle as `fill_valid`, for the same page. The bench judges the outcome by three observations: `req_ready` is low during that cycle, no response pulse appears on the next edge, and a lookup replayed afterwards hits with the newly installed translation.

The second is a fill that coincides with an invalidate of the same set. The bench judges this case by a follow-up lookup, which must miss.

// File: rtl/tlb2w_pkg.sv
package tlb2w_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_PROBE = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    RES_MISS   = 2'd0,
    RES_HIT    = 2'd1,
    RES_UPDATE = 2'd2
  } res_e;

  // Field positions inside the page-table entry second word
  localparam int PTE_C_BIT = 7;
  localparam int PTE_W_BIT = 6;
  localparam int PTE_I_BIT = 5;

  // Bank numbering
  localparam int N_BANKS   = 2;
  localparam int BANK_DATA = 0;
  localparam int BANK_INST = 1;

endpackage

// File: rtl/tlb2w_match.sv
// Compares a key against the two ways of one set.
module tlb2w_match #(
  parameter int TAG_W = 20
) (
  input  logic [TAG_W-1:0]      key,
  input  logic [1:0][TAG_W-1:0] way_tag,
  output logic                  hit,
  output logic                  hit_way
);
  logic [1:0] eq;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign eq[w] = (way_tag[w] == key);
  end

  // An all-ones key equals the invalid marker and must never match.
  assign hit     = (|eq) && (key != {TAG_W{1'b1}});
  assign hit_way = !eq[0];
endmodule

// File: rtl/tlb2w_bank.sv
// One bank: SETS sets x 2 ways, with one recency bit per set.
module tlb2w_bank
  import tlb2w_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int TAG_W = 20,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup
  input  logic             lk_en,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             lk_is_write,
  input  logic             lk_touch,
  output logic             lk_hit,
  output logic [TAG_W-1:0] lk_rpn,
  output logic             lk_wi,
  output logic             lk_need_c,
  // fill
  input  logic             fl_en,
  input  logic [TAG_W-1:0] fl_tag,
  input  logic [TAG_W-1:0] fl_rpn,
  input  logic             fl_chg,
  input  logic             fl_wi,
  // invalidate
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx
);
  localparam logic [TAG_W-1:0] TAG_NONE = {TAG_W{1'b1}};

  logic [1:0][TAG_W-1:0] tag_q [SETS];
  logic [1:0][TAG_W-1:0] rpn_q [SETS];
  logic [1:0]            chg_q [SETS];
  logic [1:0]            wi_q  [SETS];
  logic [SETS-1:0]       rec_q;

  logic [IDX_W-1:0] lk_idx, fl_idx;
  logic             hit_way;
  logic             vic;

  assign lk_idx = lk_tag[IDX_W-1:0];
  assign fl_idx = fl_tag[IDX_W-1:0];

  tlb2w_match #(.TAG_W(TAG_W)) u_match (
    .key     (lk_tag),
    .way_tag (tag_q[lk_idx]),
    .hit     (lk_hit),
    .hit_way (hit_way)
  );

  assign lk_rpn    = rpn_q[lk_idx][hit_way];
  assign lk_wi     = wi_q[lk_idx][hit_way];
  assign lk_need_c = lk_is_write && lk_hit && !chg_q[lk_idx][hit_way];

  // Victim choice for a fill
  assign vic = !rec_q[fl_idx] && (tag_q[fl_idx][0] != TAG_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tag_q[s] <= {2{TAG_NONE}};
      rec_q <= '0;
    end else begin
      if (lk_en && lk_hit && lk_touch) rec_q[lk_idx] <= hit_way;
      if (fl_en) begin
        tag_q[fl_idx][vic] <= fl_tag;
        rec_q[fl_idx]      <= vic;
      end
      // Invalidate is applied last, so it wins over a fill to the same set.
      if (inv_en) tag_q[inv_idx] <= {2{TAG_NONE}};
    end
  end

  always_ff @(posedge clk) begin
    if (fl_en) begin
      rpn_q[fl_idx][vic] <= fl_rpn;
      wi_q[fl_idx][vic]  <= fl_wi;
    end
    if (fl_en) chg_q[fl_idx][vic] <= fl_chg;
    else if (lk_en && lk_need_c) chg_q[lk_idx][hit_way] <= 1'b1;
  end
endmodule

// File: rtl/tlb2w_top.sv
module tlb2w_top
  import tlb2w_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int SETS   = 64,
  parameter int IDX_W  = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [VA_W-1:0]   req_va,
  output logic              rsp_valid,
  output logic [1:0]        rsp_res,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              rsp_wi,
  input  logic              fill_valid,
  input  logic [1:0]        fill_kind,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [VA_W-1:0]   fill_pte,
  input  logic              inv_valid,
  input  logic [IDX_W-1:0]  inv_index
);
  localparam int TAG_W = VA_W - PAGE_W;

  logic              acc;
  logic              req_inst, fill_inst, fill_ok;
  logic [TAG_W-1:0]  req_tag, fill_tag, fill_rpn;
  logic              fill_chg, fill_wi;

  logic [N_BANKS-1:0]             b_hit, b_wi, b_need_c;
  logic [N_BANKS-1:0][TAG_W-1:0]  b_rpn;

  logic              sel_hit, sel_wi, sel_need_c;
  logic [TAG_W-1:0]  sel_rpn;
  res_e              res_n;

  logic unused_fill_bits;
  assign unused_fill_bits = ^{fill_va[PAGE_W-1:0],
                              fill_pte[PAGE_W-1:PTE_C_BIT+1],
                              fill_pte[PTE_I_BIT-1:0]};

  assign req_ready = !(fill_valid || inv_valid);
  assign acc       = req_valid && req_ready;
  assign req_inst  = (acc_kind_e'(req_kind) == ACC_FETCH);
  assign fill_inst = (acc_kind_e'(fill_kind) == ACC_FETCH);
  assign fill_ok   = fill_valid && (acc_kind_e'(fill_kind) != ACC_PROBE);

  assign req_tag  = req_va[VA_W-1:PAGE_W];
  assign fill_tag = fill_va[VA_W-1:PAGE_W];
  assign fill_rpn = fill_pte[VA_W-1:PAGE_W];
  assign fill_chg = fill_pte[PTE_C_BIT];
  assign fill_wi  = fill_pte[PTE_W_BIT] | fill_pte[PTE_I_BIT];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam logic IS_INST = (b == BANK_INST);
    tlb2w_bank #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .lk_en       (acc && (req_inst == IS_INST)),
      .lk_tag      (req_tag),
      .lk_is_write (acc_kind_e'(req_kind) == ACC_WRITE),
      .lk_touch    (acc_kind_e'(req_kind) != ACC_PROBE),
      .lk_hit      (b_hit[b]),
      .lk_rpn      (b_rpn[b]),
      .lk_wi       (b_wi[b]),
      .lk_need_c   (b_need_c[b]),
      .fl_en       (fill_ok && (fill_inst == IS_INST)),
      .fl_tag      (fill_tag),
      .fl_rpn      (fill_rpn),
      .fl_chg      (fill_chg),
      .fl_wi       (fill_wi),
      .inv_en      (inv_valid),
      .inv_idx     (inv_index)
    );
  end

  assign sel_hit    = b_hit[req_inst];
  assign sel_rpn    = b_rpn[req_inst];
  assign sel_wi     = b_wi[req_inst];
  assign sel_need_c = b_need_c[req_inst];

  always_comb begin
    if (!sel_hit)        res_n = RES_MISS;
    else if (sel_need_c) res_n = RES_UPDATE;
    else                 res_n = RES_HIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_res   <= RES_MISS;
      rsp_paddr <= '0;
      rsp_wi    <= 1'b0;
    end else begin
      rsp_valid <= acc;
      if (acc) begin
        rsp_res   <= res_n;
        rsp_paddr <= sel_hit ? {sel_rpn, req_va[PAGE_W-1:0]} : '0;
        rsp_wi    <= sel_hit && sel_wi;
      end
    end
  end
endmodule

// File: rtl/tlb2w_chk.sv
module tlb2w_chk #(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_kind,
  input logic [VA_W-1:0] req_va,
  input logic            rsp_valid,
  input logic [1:0]      rsp_res,
  input logic [VA_W-1:0] rsp_paddr,
  input logic            rsp_wi
);
  // R2
  a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R11
  a_r11_no_rsp_unaccepted: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  // R3
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_res == 2'd0) |-> (rsp_paddr == '0 && !rsp_wi));

  // R3
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_res != 2'd0) |->
      (rsp_paddr[PAGE_W-1:0] == $past(req_va[PAGE_W-1:0])));

  // R6
  a_r6_update_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind != 2'd1) |=> (rsp_res != 2'd2));

  // R12
  a_r12_all_ones_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_va[VA_W-1:PAGE_W] == {(VA_W-PAGE_W){1'b1}})
      |=> (rsp_res == 2'd0));
endmodule

bind tlb2w_top tlb2w_chk #(.VA_W(VA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .req_va    (req_va),
  .rsp_valid (rsp_valid),
  .rsp_res   (rsp_res),
  .rsp_paddr (rsp_paddr),
  .rsp_wi    (rsp_wi)
);

// File: tb/tlb2w_tb.sv
`timescale 1ns/1ps
module tlb2w_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [31:0] req_va = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_res;
  logic [31:0] rsp_paddr;
  logic        rsp_wi;
  logic        fill_valid = 1'b0;
  logic [1:0]  fill_kind = 2'd0;
  logic [31:0] fill_va = '0;
  logic [31:0] fill_pte = '0;
  logic        inv_valid = 1'b0;
  logic [5:0]  inv_index = '0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  tlb2w_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_res(rsp_res), .rsp_paddr(rsp_paddr), .rsp_wi(rsp_wi),
    .fill_valid(fill_valid), .fill_kind(fill_kind), .fill_va(fill_va), .fill_pte(fill_pte),
    .inv_valid(inv_valid), .inv_index(inv_index)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 lookup, 1 fill, 2 invalidate
    logic [1:0]  kind;
    logic [31:0] va;
    logic [31:0] pte;
    logic [1:0]  res;
    logic [31:0] pa;
    logic        wi;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 32'h00003abc, 32'h0,        2'd0, 32'h0,        1'b0, 4'd1},  // R1 empty after reset
    '{2'd1, 2'd0, 32'h00003000, 32'h12345180, 2'd0, 32'h0,        1'b0, 4'd8},  // R8 -> way0
    '{2'd0, 2'd0, 32'h00003abc, 32'h0,        2'd1, 32'h12345abc, 1'b0, 4'd3},  // R3 hit
    '{2'd0, 2'd2, 32'h00003abc, 32'h0,        2'd0, 32'h0,        1'b0, 4'd4},  // R4 inst bank empty
    '{2'd1, 2'd0, 32'h00043000, 32'h0AAAA140, 2'd0, 32'h0,        1'b0, 4'd8},  // R8 -> way1
    '{2'd0, 2'd0, 32'h00043010, 32'h0,        2'd1, 32'h0AAAA010, 1'b1, 4'd5},  // R5 W set
    '{2'd0, 2'd0, 32'h00003004, 32'h0,        2'd1, 32'h12345004, 1'b0, 4'd7},  // R7 touch way0
    '{2'd1, 2'd0, 32'h00083000, 32'h555551A0, 2'd0, 32'h0,        1'b0, 4'd8},  // R8 replaces way1
    '{2'd0, 2'd0, 32'h00043010, 32'h0,        2'd0, 32'h0,        1'b0, 4'd8},  // R8 evicted
    '{2'd0, 2'd0, 32'h00083ffc, 32'h0,        2'd1, 32'h55555ffc, 1'b1, 4'd5},  // R5 I set
    '{2'd0, 2'd0, 32'h00003000, 32'h0,        2'd1, 32'h12345000, 1'b0, 4'd3},
    '{2'd0, 2'd0, 32'h00083000, 32'h0,        2'd1, 32'h55555000, 1'b1, 4'd7},  // R7 touch way1
    '{2'd1, 2'd0, 32'h000C3000, 32'h00777180, 2'd0, 32'h0,        1'b0, 4'd8},  // R8 -> way0
    '{2'd0, 2'd0, 32'h00003000, 32'h0,        2'd0, 32'h0,        1'b0, 4'd8},
    '{2'd0, 2'd0, 32'h000C3123, 32'h0,        2'd1, 32'h00777123, 1'b0, 4'd3},
    '{2'd0, 2'd0, 32'h00083123, 32'h0,        2'd1, 32'h55555123, 1'b1, 4'd8},
    '{2'd1, 2'd1, 32'h00005000, 32'h0BEEF100, 2'd0, 32'h0,        1'b0, 4'd6},  // clean page
    '{2'd0, 2'd1, 32'h00005008, 32'h0,        2'd2, 32'h0BEEF008, 1'b0, 4'd6},  // R6 update
    '{2'd0, 2'd1, 32'h00005008, 32'h0,        2'd1, 32'h0BEEF008, 1'b0, 4'd6},  // R6 now dirty
    '{2'd1, 2'd0, 32'h00006000, 32'h0CAFE100, 2'd0, 32'h0,        1'b0, 4'd6},
    '{2'd0, 2'd3, 32'h00006444, 32'h0,        2'd1, 32'h0CAFE444, 1'b0, 4'd6},  // R6 probe clean
    '{2'd0, 2'd0, 32'h00006444, 32'h0,        2'd1, 32'h0CAFE444, 1'b0, 4'd6},  // R6 read clean
    '{2'd0, 2'd1, 32'h00006444, 32'h0,        2'd2, 32'h0CAFE444, 1'b0, 4'd6},
    '{2'd0, 2'd3, 32'h000C3000, 32'h0,        2'd1, 32'h00777000, 1'b0, 4'd7},  // R7 probe no touch
    '{2'd1, 2'd0, 32'h00103000, 32'h01111180, 2'd0, 32'h0,        1'b0, 4'd7},
    '{2'd0, 2'd0, 32'h00083000, 32'h0,        2'd1, 32'h55555000, 1'b1, 4'd7},  // R7 way1 kept
    '{2'd0, 2'd0, 32'h000C3000, 32'h0,        2'd0, 32'h0,        1'b0, 4'd7},
    '{2'd1, 2'd3, 32'h00007000, 32'h00999180, 2'd0, 32'h0,        1'b0, 4'd9},
    '{2'd0, 2'd0, 32'h00007000, 32'h0,        2'd0, 32'h0,        1'b0, 4'd9},  // R9 probe fill ignored
    '{2'd1, 2'd2, 32'h00003000, 32'h022221A0, 2'd0, 32'h0,        1'b0, 4'd4},
    '{2'd0, 2'd2, 32'h00003200, 32'h0,        2'd1, 32'h02222200, 1'b1, 4'd4},  // R4 inst hit
    '{2'd0, 2'd0, 32'h00003200, 32'h0,        2'd0, 32'h0,        1'b0, 4'd4},  // R4 data misses
    '{2'd2, 2'd0, 32'h00003000, 32'h0,        2'd0, 32'h0,        1'b0, 4'd10},
    '{2'd0, 2'd2, 32'h00003200, 32'h0,        2'd0, 32'h0,        1'b0, 4'd10}, // R10 inst cleared
    '{2'd0, 2'd0, 32'h00083000, 32'h0,        2'd0, 32'h0,        1'b0, 4'd10}, // R10 data cleared
    '{2'd0, 2'd0, 32'h00005000, 32'h0,        2'd1, 32'h0BEEF000, 1'b0, 4'd10}  // R10 other set kept
  };

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the response edge.
  task automatic do_op(input vec_t v);
    logic [35:0] act, exp;
    case (v.op)
      2'd0: begin req_valid = 1'b1; req_kind = v.kind; req_va = v.va; end
      2'd1: begin fill_valid = 1'b1; fill_kind = v.kind; fill_va = v.va; fill_pte = v.pte; end
      default: begin inv_valid = 1'b1; inv_index = v.va[17:12]; end
    endcase
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0;
    if (v.op == 2'd0) begin
      act = {rsp_valid, rsp_res, rsp_wi, rsp_paddr};
      exp = {1'b1, v.res, v.wi, v.pa};
      check(act == exp, int'(v.rq), "lookup", act, exp);
    end
  endtask

  task automatic lookup(input logic [1:0] k, input logic [31:0] va, input logic [1:0] res,
                        input logic [31:0] pa, input logic wi, input int rq);
    vec_t v;
    v = '{2'd0, k, va, 32'h0, res, pa, wi, 4'(rq)};
    do_op(v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == 1'b0, 1, "rsp_valid after reset", 36'(rsp_valid), 36'h0);
    // R11 ready high when idle
    check(req_ready == 1'b1, 11, "ready idle", 36'(req_ready), 36'h1);

    for (int i = 0; i < NV; i++) do_op(VECS[i]);

    // R11: lookup and fill in the same cycle, lookup is held back
    req_valid = 1'b1; req_kind = 2'd0; req_va = 32'h00009000;
    fill_valid = 1'b1; fill_kind = 2'd0; fill_va = 32'h00009000; fill_pte = 32'h0ABCD180;
    #1;
    check(req_ready == 1'b0, 11, "ready during fill", 36'(req_ready), 36'h0);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
    check(rsp_valid == 1'b0, 11, "no response when stalled", 36'(rsp_valid), 36'h0);
    do_op('{2'd0, 2'd0, 32'h00009000, 32'h0, 2'd1, 32'h0ABCD000, 1'b0, 4'd11});

    // R10: fill and invalidate to the same set in one cycle
    fill_valid = 1'b1; fill_kind = 2'd0; fill_va = 32'h0000A000; fill_pte = 32'h0DDDD180;
    inv_valid = 1'b1; inv_index = 6'h0A;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0; inv_valid = 1'b0;
    lookup(2'd0, 32'h0000A000, 2'd0, 32'h0, 1'b0, 10);

    // R12: an all-ones page never hits, even after a fill to it
    do_op('{2'd1, 2'd0, 32'hFFFFF000, 32'h0EEEE180, 2'd0, 32'h0, 1'b0, 4'd12});
    lookup(2'd0, 32'hFFFFF010, 2'd0, 32'h0, 1'b0, 12);

    // R1: reset again empties the arrays
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    lookup(2'd0, 32'h00005000, 2'd0, 32'h0, 1'b0, 1);
    lookup(2'd0, 32'h00009000, 2'd0, 32'h0, 1'b0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule